// File: doc/BRIEF.md
# Neighbourhood Coalescing Completion Scanner

This block sits beside a group of page table walkers and a buffer of page walk requests that have not yet started. Whenever any walker gets a page table line back from memory (eight 64-bit entries), the scanner looks up that walker's row in a per-walker service table. The row holds the virtual page number (VPN) being walked and the table level just read. The scanner then compares every pending request in the buffer against the aligned region that the line covers. At the leaf level, each matching request is finished at once, using the frame number from its own slot of the line. At an upper level, each matching request records the next-node frame and the level it has reached. Neither case costs an extra memory access.

The walkers, memory access and the choice of which request starts a new walk are outside the block. Those parts load the service table, insert requests and read each buffer entry through a query port. Finished requests stay in their buffer entry and are drained one per cycle on the response port, lowest buffer index first.

The scan control has two states. IDLE moves to SCAN when `line_vld` is high, and the line and walker id are captured on that edge. SCAN returns to IDLE unconditionally, and every buffer entry is updated on that edge.

Top module: `nbr_coalesce_scan`

## Requirements
- R1: After reset the buffer is empty, `buf_full`, `scan_busy` and `rsp_vld` are 0, and every queried entry reads as not valid.
- R2: An inserted request goes into the lowest-index free entry (visible through `q_vpn`). `buf_full` is 1 only when all entries are valid.
- R3: Level code 0 is the leaf. A request matches a leaf line when its VPN bits [35:3] equal the walked VPN's bits [35:3]. It is then completed with the frame from PTE bits [51:12] of slot VPN[2:0].
- R4: A pending request outside the line's region stays valid, keeps its fields and produces no response.
- R5: At upper level code k (1..3), a request matches when VPN bits [35:3+9k] equal the walked VPN's. The request then records `q_co_vld`=1, `q_co_lvl`=k-1 and `q_co_frame` from slot VPN[9k+2:9k], and no response is issued.
- R6: On an upper match, the coalescing flag is set only if VPN bits [35:9k] also equal the walked VPN's, meaning the walk's next node covers the request. A flagged entry that misses a later line from the same walker has its flag cleared.
- R7: A matching slot whose present bit (PTE bit 0) is 0 completes the request with `rsp_fault`=1 and frame 0, at any level.
- R8: Completed requests leave on the response port one per cycle in ascending buffer index. The first response appears on the second clock edge after the edge that accepts the line, and the entry is freed when its response is issued.
- R9: `scan_busy` is high for exactly the one cycle after a line is accepted.
- R10: The scan uses the service-table row of the walker named by `line_wid`, and rows of other walkers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Insert a pending request |
| req_vpn | input | 36 | VPN of the inserted request |
| buf_full | output | 1 | All buffer entries valid |
| svc_we | input | 1 | Write a service-table row |
| svc_wid | input | 3 | Walker id of the row written |
| svc_vpn | input | 36 | VPN being walked |
| svc_lvl | input | 2 | Level being read (0 leaf .. 3 root) |
| line_vld | input | 1 | A page table line has arrived |
| line_wid | input | 3 | Walker that received the line |
| line_data | input | 512 | Eight PTEs, slot n at bits [64n+63:64n] |
| scan_busy | output | 1 | Scan in progress |
| rsp_vld | output | 1 | Completion valid |
| rsp_vpn | output | 36 | VPN completed |
| rsp_frame | output | 40 | Frame number (0 on fault) |
| rsp_fault | output | 1 | Entry was not present |
| q_idx | input | 4 | Buffer entry to inspect |
| q_vld | output | 1 | Entry valid |
| q_vpn | output | 36 | Entry VPN |
| q_co_vld | output | 1 | Entry has coalesced at an upper level |
| q_co_lvl | output | 2 | Level of the recorded next node |
| q_co_frame | output | 40 | Recorded next-node frame |
| q_flag | output | 1 | Entry still covered by an ongoing walk |

## Verification
On every cycle, the assertions check that the busy pulse lasts exactly one cycle after an accepted line and that an entry becomes complete only on a scan edge. They also check that a response is issued only when a completed entry existed, that faulted responses carry a zero frame and that a flagged entry has always coalesced. Only the directed scenarios can show the values themselves: that the correct slot of the line is chosen at each level, that the region boundaries are correct, that the flag is set and cleared against the walk's next node, and that drain order and cycle timing are correct.

// File: rtl/nbr_pkg.sv
package nbr_pkg;
    localparam int VPN_W    = 36;
    localparam int FRAME_W  = 40;
    localparam int PTE_W    = 64;
    localparam int PG_SH    = 12;
    localparam int SLOT_W   = 3;
    localparam int SLOTS    = 1 << SLOT_W;
    localparam int IDX_BITS = 9;
    localparam int LVL_W    = 2;
    localparam logic [LVL_W-1:0] LVL_LEAF = '0;

    typedef enum logic [0:0] {SC_IDLE, SC_SCAN} scan_st_e;

    typedef struct packed {
        logic               vld;
        logic               done;
        logic               fault;
        logic [VPN_W-1:0]   vpn;
        logic               co_vld;
        logic [LVL_W-1:0]   co_lvl;
        logic [FRAME_W-1:0] co_frame;
        logic               flag;
        logic [FRAME_W-1:0] res;
    } req_t;
endpackage

// File: rtl/nbr_svc_table.sv
module nbr_svc_table
    import nbr_pkg::*;
#(
    parameter int NWALK = 8,
    localparam int WW = $clog2(NWALK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WW-1:0]    wid,
    input  logic [VPN_W-1:0] wvpn,
    input  logic [LVL_W-1:0] wlvl,
    input  logic [WW-1:0]    rid,
    output logic [VPN_W-1:0] rvpn,
    output logic [LVL_W-1:0] rlvl
);
    logic [VPN_W-1:0] vpn_q [NWALK];
    logic [LVL_W-1:0] lvl_q [NWALK];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < NWALK; w++) begin
                vpn_q[w] <= '0;
                lvl_q[w] <= '0;
            end
        end else if (we) begin
            vpn_q[wid] <= wvpn;
            lvl_q[wid] <= wlvl;
        end
    end

    assign rvpn = vpn_q[rid];
    assign rlvl = lvl_q[rid];
endmodule

// File: rtl/nbr_match.sv
module nbr_match
    import nbr_pkg::*;
(
    input  logic [VPN_W-1:0]       ent_vpn,
    input  logic [VPN_W-1:0]       walk_vpn,
    input  logic [LVL_W-1:0]       lvl,
    input  logic [SLOTS*PTE_W-1:0] line,
    output logic                   hit,
    output logic                   covered,
    output logic                   present,
    output logic [FRAME_W-1:0]     frame
);
    logic [VPN_W-1:0]  diff, nb_mask, cov_mask, one_v;
    logic [SLOT_W-1:0] slot;
    logic [PTE_W-1:0]  pte_sel;
    logic              unused_pte;
    int                base;

    always_comb begin
        one_v    = VPN_W'(1);
        base     = IDX_BITS * int'(lvl);
        diff     = ent_vpn ^ walk_vpn;
        // region of one line: all bits above this level's slot select
        nb_mask  = ~((one_v << (base + SLOT_W)) - one_v);
        // node reached next by the walk: bits above this level's index
        cov_mask = ~((one_v << base) - one_v);
        hit      = (diff & nb_mask) == '0;
        covered  = (diff & cov_mask) == '0;
        slot     = SLOT_W'(ent_vpn >> base);
        pte_sel  = line[int'(slot)*PTE_W +: PTE_W];
        present  = pte_sel[0];
        frame    = pte_sel[PG_SH +: FRAME_W];
    end

    assign unused_pte = ^{pte_sel[PTE_W-1:PG_SH+FRAME_W], pte_sel[PG_SH-1:1]};
endmodule

// File: rtl/nbr_first.sv
module nbr_first #(
    parameter int N = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/nbr_coalesce_scan.sv
module nbr_coalesce_scan
    import nbr_pkg::*;
#(
    parameter int NWALK = 8,
    parameter int NBUF  = 16,
    localparam int WID_W = $clog2(NWALK),
    localparam int IDX_W = $clog2(NBUF)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_vld,
    input  logic [VPN_W-1:0]       req_vpn,
    output logic                   buf_full,
    input  logic                   svc_we,
    input  logic [WID_W-1:0]       svc_wid,
    input  logic [VPN_W-1:0]       svc_vpn,
    input  logic [LVL_W-1:0]       svc_lvl,
    input  logic                   line_vld,
    input  logic [WID_W-1:0]       line_wid,
    input  logic [SLOTS*PTE_W-1:0] line_data,
    output logic                   scan_busy,
    output logic                   rsp_vld,
    output logic [VPN_W-1:0]       rsp_vpn,
    output logic [FRAME_W-1:0]     rsp_frame,
    output logic                   rsp_fault,
    input  logic [IDX_W-1:0]       q_idx,
    output logic                   q_vld,
    output logic [VPN_W-1:0]       q_vpn,
    output logic                   q_co_vld,
    output logic [LVL_W-1:0]       q_co_lvl,
    output logic [FRAME_W-1:0]     q_co_frame,
    output logic                   q_flag
);
    scan_st_e               st, st_nx;
    logic [WID_W-1:0]       cap_wid;
    logic [SLOTS*PTE_W-1:0] cap_line;
    logic [VPN_W-1:0]       walk_vpn;
    logic [LVL_W-1:0]       walk_lvl;

    logic [NBUF-1:0] vld_vec, done_vec, flag_vec, co_vec;
    req_t            ent_v [NBUF];
    logic            free_any, pick_vld, ins_go;
    logic [IDX_W-1:0] free_idx, pick_idx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= SC_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            SC_IDLE: if (line_vld) st_nx = SC_SCAN;
            SC_SCAN: st_nx = SC_IDLE;
            default: st_nx = SC_IDLE;
        endcase
    end

    assign scan_busy = (st == SC_SCAN);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_wid  <= '0;
            cap_line <= '0;
        end else if (st == SC_IDLE && line_vld) begin
            cap_wid  <= line_wid;
            cap_line <= line_data;
        end
    end

    nbr_svc_table #(.NWALK(NWALK)) u_svc (
        .clk(clk), .rst_n(rst_n),
        .we(svc_we), .wid(svc_wid), .wvpn(svc_vpn), .wlvl(svc_lvl),
        .rid(cap_wid), .rvpn(walk_vpn), .rlvl(walk_lvl)
    );

    nbr_first #(.N(NBUF)) u_free (.req(~vld_vec), .any(free_any), .idx(free_idx));
    nbr_first #(.N(NBUF)) u_pick (.req(done_vec),  .any(pick_vld), .idx(pick_idx));

    assign ins_go   = req_vld && free_any;
    assign buf_full = &vld_vec;

    for (genvar g = 0; g < NBUF; g++) begin : g_ent
        req_t             e_r;
        logic [WID_W-1:0] own_r;
        logic             hit, cov, pres;
        logic [FRAME_W-1:0] frm;

        nbr_match u_m (
            .ent_vpn(e_r.vpn), .walk_vpn(walk_vpn), .lvl(walk_lvl), .line(cap_line),
            .hit(hit), .covered(cov), .present(pres), .frame(frm)
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                e_r   <= '0;
                own_r <= '0;
            end else if (pick_vld && pick_idx == IDX_W'(g)) begin
                e_r <= '0;
            end else if (ins_go && free_idx == IDX_W'(g)) begin
                e_r     <= '0;
                e_r.vld <= 1'b1;
                e_r.vpn <= req_vpn;
            end else if (scan_busy && e_r.vld && !e_r.done) begin
                if (hit) begin
                    if (!pres) begin
                        e_r.done  <= 1'b1;
                        e_r.fault <= 1'b1;
                        e_r.res   <= '0;
                        e_r.flag  <= 1'b0;
                    end else if (walk_lvl == LVL_LEAF) begin
                        e_r.done  <= 1'b1;
                        e_r.fault <= 1'b0;
                        e_r.res   <= frm;
                        e_r.flag  <= 1'b0;
                    end else begin
                        e_r.co_vld   <= 1'b1;
                        e_r.co_lvl   <= walk_lvl - LVL_W'(1);
                        e_r.co_frame <= frm;
                        e_r.flag     <= cov;
                        own_r        <= cap_wid;
                    end
                end else if (e_r.flag && own_r == cap_wid) begin
                    e_r.flag <= 1'b0;
                end
            end
        end

        assign vld_vec[g]  = e_r.vld;
        assign done_vec[g] = e_r.vld & e_r.done;
        assign flag_vec[g] = e_r.flag;
        assign co_vec[g]   = e_r.co_vld;
        assign ent_v[g]    = e_r;
    end

    // outputs: one completion per cycle, lowest index first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld   <= 1'b0;
            rsp_vpn   <= '0;
            rsp_frame <= '0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_vld <= pick_vld;
            if (pick_vld) begin
                rsp_vpn   <= ent_v[pick_idx].vpn;
                rsp_frame <= ent_v[pick_idx].res;
                rsp_fault <= ent_v[pick_idx].fault;
            end
        end
    end

    assign q_vld      = ent_v[q_idx].vld;
    assign q_vpn      = ent_v[q_idx].vpn;
    assign q_co_vld   = ent_v[q_idx].co_vld;
    assign q_co_lvl   = ent_v[q_idx].co_lvl;
    assign q_co_frame = ent_v[q_idx].co_frame;
    assign q_flag     = ent_v[q_idx].flag;
endmodule

// File: rtl/nbr_coalesce_scan_chk.sv
module nbr_coalesce_scan_chk #(
    parameter int NBUF = 16,
    parameter int FW   = 40
) (
    input logic            clk,
    input logic            rst_n,
    input logic            line_vld,
    input logic            scan_busy,
    input logic            rsp_vld,
    input logic            rsp_fault,
    input logic [FW-1:0]   rsp_frame,
    input logic [NBUF-1:0] done_vec,
    input logic [NBUF-1:0] flag_vec,
    input logic [NBUF-1:0] co_vec
);
    a_r9_busy_after_line: assert property (@(posedge clk) disable iff (!rst_n)
        (line_vld && !scan_busy) |=> scan_busy);

    a_r9_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
        scan_busy |=> !scan_busy);

    a_r3_done_on_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (|(done_vec & ~$past(done_vec))) |-> $past(scan_busy));

    a_r8_rsp_from_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> $past(|done_vec));

    a_r7_fault_zero_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && rsp_fault) |-> (rsp_frame == '0));

    a_r6_flag_has_coalesced: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_vec & ~co_vec) == '0);
endmodule

bind nbr_coalesce_scan nbr_coalesce_scan_chk #(.NBUF(NBUF), .FW(nbr_pkg::FRAME_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_vld(line_vld), .scan_busy(scan_busy),
    .rsp_vld(rsp_vld), .rsp_fault(rsp_fault), .rsp_frame(rsp_frame),
    .done_vec(done_vec), .flag_vec(flag_vec), .co_vec(co_vec)
);

// File: tb/sim_nbr_coalesce_scan.sv
`timescale 1ns/1ps
module sim_nbr_coalesce_scan;
    logic clk = 1'b0;
    logic rst_n;
    logic req_vld; logic [35:0] req_vpn; logic buf_full;
    logic svc_we; logic [2:0] svc_wid; logic [35:0] svc_vpn; logic [1:0] svc_lvl;
    logic line_vld; logic [2:0] line_wid; logic [511:0] line_data;
    logic scan_busy, rsp_vld, rsp_fault; logic [35:0] rsp_vpn; logic [39:0] rsp_frame;
    logic [3:0] q_idx; logic q_vld, q_co_vld, q_flag; logic [35:0] q_vpn;
    logic [1:0] q_co_lvl; logic [39:0] q_co_frame;

    int total = 0;
    int bad = 0;
    bit busy_seen;

    always #10 clk = ~clk;

    nbr_coalesce_scan u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req_vld = 0; req_vpn = '0; svc_we = 0; svc_wid = '0; svc_vpn = '0;
        svc_lvl = '0; line_vld = 0; line_wid = '0; line_data = '0; q_idx = '0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic push(input logic [35:0] v);
        req_vld = 1; req_vpn = v; tick(); req_vld = 0;
    endtask

    task automatic set_svc(input int id, input logic [35:0] v, input logic [1:0] l);
        svc_we = 1; svc_wid = 3'(id); svc_vpn = v; svc_lvl = l; tick(); svc_we = 0;
    endtask

    function automatic logic [511:0] mkline(input logic [39:0] base, input logic [7:0] absent);
        logic [511:0] d = '0;
        for (int k = 0; k < 8; k++)
            d[k*64 +: 64] = {12'h0, base + 40'(k), 11'h0, ~absent[k]};
        return d;
    endfunction

    task automatic send_line(input int id, input logic [511:0] d);
        line_vld = 1; line_wid = 3'(id); line_data = d;
        tick();
        line_vld = 0;
        busy_seen = scan_busy;
        tick();
    endtask

    task automatic query(input int idx);
        q_idx = 4'(idx); #1;
    endtask

    task automatic expect_rsp(input logic [35:0] v, input logic [39:0] f, input bit flt, input string tag);
        tick();
        chk(rsp_vld == 1'b1, {tag, " rsp_vld"}, 64'(rsp_vld), 1);
        chk(rsp_vpn == v, {tag, " vpn"}, 64'(rsp_vpn), 64'(v));
        chk(rsp_frame == f, {tag, " frame"}, 64'(rsp_frame), 64'(f));
        chk(rsp_fault == flt, {tag, " fault"}, 64'(rsp_fault), 64'(flt));
    endtask

    // R1
    task automatic t_reset();
        do_reset();
        chk(rsp_vld == 0, "R1 rsp_vld", 64'(rsp_vld), 0);
        chk(scan_busy == 0, "R1 busy", 64'(scan_busy), 0);
        chk(buf_full == 0, "R1 full", 64'(buf_full), 0);
        query(0);
        chk(q_vld == 0, "R1 entry0", 64'(q_vld), 0);
    endtask

    // R2
    task automatic t_full();
        do_reset();
        for (int i = 0; i < 15; i++) push(36'(i * 8 + 36'h1000));
        chk(buf_full == 0, "R2 not full at 15", 64'(buf_full), 0);
        push(36'h5000);
        chk(buf_full == 1, "R2 full at 16", 64'(buf_full), 1);
        query(15);
        chk(q_vpn == 36'h5000, "R2 last entry", 64'(q_vpn), 64'h5000);
    endtask

    // R3 R4 R8 R9 R2
    task automatic t_leaf();
        logic [35:0] w = 36'h000123450;
        logic [35:0] d = 36'h0FFFFFFF0;
        do_reset();
        set_svc(2, w, 2'd0);
        push(w + 1); push(w + 7); push(w + 8);
        send_line(2, mkline(40'h100, 8'h00));
        chk(busy_seen == 1, "R9 busy after line", 64'(busy_seen), 1);
        chk(scan_busy == 0, "R9 busy drops", 64'(scan_busy), 0);
        chk(rsp_vld == 0, "R8 no rsp at scan edge", 64'(rsp_vld), 0);
        expect_rsp(w + 1, 40'h101, 0, "R3 R8 first");
        expect_rsp(w + 7, 40'h107, 0, "R3 R8 second");
        tick();
        chk(rsp_vld == 0, "R4 no third rsp", 64'(rsp_vld), 0);
        query(2);
        chk(q_vld == 1 && q_co_vld == 0, "R4 outsider pending", 64'({q_vld, q_co_vld}), 64'b10);
        query(0);
        chk(q_vld == 0, "R8 entry0 freed", 64'(q_vld), 0);
        push(d);
        query(0);
        chk(q_vpn == d, "R2 lowest free", 64'(q_vpn), 64'(d));
        set_svc(2, w + 8, 2'd0);
        send_line(2, mkline(40'h180, 8'h00));
        expect_rsp(w + 8, 40'h180, 0, "R3 second line");
        query(0);
        chk(q_vld == 1, "R4 unrelated kept", 64'(q_vld), 1);
    endtask

    // R5 R6 R7 R10
    task automatic t_upper();
        logic [35:0] v = {15'h1234, 3'd3, 18'h0};
        logic [35:0] p = {15'h1234, 3'd3, 18'h3F155};
        logic [35:0] q = {15'h1234, 3'd6, 18'h00002};
        logic [35:0] r = {15'h1235, 3'd3, 18'h0};
        do_reset();
        push(p); push(q); push(r);
        set_svc(5, v, 2'd2);
        send_line(5, mkline(40'h200, 8'h00));
        tick();
        chk(rsp_vld == 0, "R5 no response", 64'(rsp_vld), 0);
        query(0);
        chk(q_co_vld == 1 && q_co_lvl == 2'd1, "R5 p level", 64'({q_co_vld, q_co_lvl}), 64'b101);
        chk(q_co_frame == 40'h203, "R5 p frame", 64'(q_co_frame), 64'h203);
        chk(q_flag == 1, "R6 p flagged", 64'(q_flag), 1);
        query(1);
        chk(q_co_frame == 40'h206, "R5 q frame", 64'(q_co_frame), 64'h206);
        chk(q_flag == 0, "R6 q not covered", 64'(q_flag), 0);
        query(2);
        chk(q_co_vld == 0, "R5 r outside", 64'(q_co_vld), 0);
        set_svc(5, v, 2'd1);
        send_line(5, mkline(40'h400, 8'h00));
        query(0);
        chk(q_flag == 0, "R6 p flag cleared", 64'(q_flag), 0);
        chk(q_co_frame == 40'h203, "R6 p fields kept", 64'(q_co_frame), 64'h203);
        query(1);
        chk(q_co_frame == 40'h206, "R4 q fields kept", 64'(q_co_frame), 64'h206);
        set_svc(1, p, 2'd0);
        send_line(1, mkline(40'h500, 8'h20));
        expect_rsp(p, 40'h0, 1, "R7 fault");
        set_svc(3, q, 2'd0);
        set_svc(4, r, 2'd0);
        send_line(4, mkline(40'h300, 8'h00));
        expect_rsp(r, 40'h300, 0, "R10 walker4 row");
        query(1);
        chk(q_vld == 1, "R10 q untouched", 64'(q_vld), 1);
        send_line(3, mkline(40'h300, 8'h00));
        expect_rsp(q, 40'h302, 0, "R10 walker3 row");
    endtask

    initial begin
        t_reset();
        t_full();
        t_leaf();
        t_upper();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        total++;
        bad++;
        $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule